// File: doc/BRIEF.md
# Push-Button Power Sequencer

This block is the control state machine that powers an application processor up and down. It drives seven regulator enable lines, an active-low processor reset and an active-low button status line. A new power-up can come from a rising edge on the push-button input or on the external wake input. Regulators 3 and 5 come up first. Once regulator 5 reports power-good, regulators 1 and 2 follow while the processor is held in reset. A counter then holds reset low for a fixed number of cycles, and reset is released only after regulator 5 has stayed good for that whole window.

The power-up is only provisional. The processor has to claim power by raising its hold line or its enable line. If the trigger input goes low first, the sequence aborts and every enable is cleared. After a claim, hold keeps regulators 1, 2 and 5 on, and enable drives regulators 3, 4, 6 and 7. When both lines fall, the block returns to off. A configuration input chooses whether regulator 3 follows the button or stays independent of it.

States: OFF (all off, reset low), RAMP (reg3 and reg5 on, waiting for power-good), RESET (reg1, reg2, reg3 and reg5 on, reset timer running), BOOT (reset released, waiting for a claim) and ON (claimed). Transitions: OFF→RAMP on a trigger edge. RAMP→RESET on power-good. RESET→BOOT when the timer expires. BOOT→ON on hold or enable. RAMP/RESET/BOOT→OFF when the trigger is released without a claim. ON→OFF when hold and enable are both low.

Top module: `pb_power_seq`

## Requirements
- R1: While reset is asserted and directly after it, reg_en is 0, rst_out_n is 0 and pb_stat_n is 1.
- R2: In OFF, a rising edge on the synchronized push-button moves the block to RAMP on the next clock. In RAMP, reg_en is 7'b0010100 (bit i is regulator i+1, so regulators 3 and 5 are on).
- R3: In RAMP, pg5 high moves the block to RESET. In RESET, regulators 1, 2, 3 and 5 are on (7'b0010111) and rst_out_n stays 0.
- R4: rst_out_n rises only after RST_CYCLES consecutive clocks in RESET with pg5 high. A low pg5 during that window restarts the count.
- R5: In RAMP or RESET, a low trigger (synchronized push-button OR synchronized wake) moves the block to OFF and clears every enable. In BOOT the same happens when hold and enable are also both low.
- R6: In BOOT, hold or enable high moves the block to ON. ON holds for as long as at least one of them is high, whatever the trigger does.
- R7: In ON, hold drives regulators 1, 2 and 5 (bits 0, 1, 4), and enable drives regulators 4, 6 and 7 (bits 3, 5, 6) and regulator 3 (bit 2).
- R8: A rising edge on the wake input starts the same sequence as the push-button, and pb_stat_n stays 1 throughout.
- R9: In ON with enable low, regulator 3 follows the synchronized push-button when r3_indep is 0 and is off when r3_indep is 1.
- R10: In ON, hold and enable both low moves the block to OFF on the next clock, with all enables cleared and rst_out_n low.
- R11: In OFF, a level held high on a trigger input does not restart the sequence. Only a new rising edge does.
- R12: pb_stat_n is low exactly while the push-button input, delayed by two clocks of synchronization, is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pb_in | input | 1 | Push-button level, asynchronous, high = pressed |
| wake_in | input | 1 | External wake level, asynchronous |
| pg5 | input | 1 | Power-good of regulator 5 |
| hold_in | input | 1 | Processor hold handshake |
| en_in | input | 1 | Processor enable handshake |
| r3_indep | input | 1 | 1 = regulator 3 does not follow the push-button |
| reg_en | output | 7 | Regulator enables, bit i = regulator i+1 |
| rst_out_n | output | 1 | Active-low processor reset |
| pb_stat_n | output | 1 | Active-low push-button status |

## Verification
The assertions treat pg5, hold_in, en_in and r3_indep as synchronous to clk. Only pb_in and wake_in are allowed to be asynchronous. The assertions also assume the trigger edges they reason about are seen after synchronization. The bench changes every input only on falling clock edges, so every input is stable around each rising edge. It compares the outputs against a behavioural model at each falling edge, before the next input change. The scenarios cover early release in each provisional state, a pg5 dropout during the reset window, wake-only start-up, each handshake combination and a held button after shutdown.

// File: rtl/pbseq_pkg.sv
package pbseq_pkg;
    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_RAMP = 3'd1,
        ST_RST  = 3'd2,
        ST_BOOT = 3'd3,
        ST_ON   = 3'd4
    } pwr_state_t;

    localparam int NUM_REG  = 7;
    localparam int REG1_BIT = 0;
    localparam int REG2_BIT = 1;
    localparam int REG3_BIT = 2;
    localparam int REG4_BIT = 3;
    localparam int REG5_BIT = 4;
    localparam int REG6_BIT = 5;
    localparam int REG7_BIT = 6;
endpackage

// File: rtl/pbseq_sync.sv
module pbseq_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/pbseq_timer.sv
module pbseq_timer #(
    parameter int RST_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic pg_ok,
    output logic done
);
    localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign done = run && pg_ok && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (!run || !pg_ok) cnt <= '0;
        else if (cnt != LAST)    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pbseq_fsm.sv
module pbseq_fsm
    import pbseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pb_s,
    input  logic               wk_s,
    input  logic               pg5,
    input  logic               hold_in,
    input  logic               en_in,
    input  logic               r3_indep,
    input  logic               tmr_done,
    output logic               tmr_run,
    output logic [NUM_REG-1:0] reg_en,
    output logic               rst_out_n
);
    pwr_state_t state, state_nx;
    logic pb_d, wk_d;
    logic start, trig, claim;

    assign start = (pb_s && !pb_d) || (wk_s && !wk_d);
    assign trig  = pb_s || wk_s;
    assign claim = hold_in || en_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            pb_d  <= 1'b0;
            wk_d  <= 1'b0;
        end else begin
            state <= state_nx;
            pb_d  <= pb_s;
            wk_d  <= wk_s;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:  if (start) state_nx = ST_RAMP;
            ST_RAMP: begin
                if (!trig)    state_nx = ST_OFF;
                else if (pg5) state_nx = ST_RST;
            end
            ST_RST: begin
                if (!trig)         state_nx = ST_OFF;
                else if (tmr_done) state_nx = ST_BOOT;
            end
            ST_BOOT: begin
                if (claim)      state_nx = ST_ON;
                else if (!trig) state_nx = ST_OFF;
            end
            ST_ON:   if (!claim) state_nx = ST_OFF;
            default: state_nx = ST_OFF;
        endcase
    end

    always_comb begin
        reg_en    = '0;
        rst_out_n = 1'b0;
        tmr_run   = 1'b0;
        unique case (state)
            ST_OFF: ;
            ST_RAMP: begin
                reg_en[REG3_BIT] = 1'b1;
                reg_en[REG5_BIT] = 1'b1;
            end
            ST_RST, ST_BOOT: begin
                reg_en[REG1_BIT] = 1'b1;
                reg_en[REG2_BIT] = 1'b1;
                reg_en[REG3_BIT] = 1'b1;
                reg_en[REG5_BIT] = 1'b1;
                tmr_run          = (state == ST_RST);
                rst_out_n        = (state == ST_BOOT);
            end
            ST_ON: begin
                rst_out_n        = 1'b1;
                reg_en[REG1_BIT] = hold_in;
                reg_en[REG2_BIT] = hold_in;
                reg_en[REG5_BIT] = hold_in;
                reg_en[REG4_BIT] = en_in;
                reg_en[REG6_BIT] = en_in;
                reg_en[REG7_BIT] = en_in;
                reg_en[REG3_BIT] = en_in || (!r3_indep && pb_s);
            end
            default: ;
        endcase
    end

    assert_start_ramp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && start) |=> (reg_en == 7'b0010100));
    assert_release_after_timer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> $past(tmr_done));
    assert_abort_unclaimed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RAMP || state == ST_RST) && !trig) |=> (reg_en == '0));
    assert_claim_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BOOT && claim) |=> (state == ST_ON && rst_out_n));
    assert_drop_to_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ON && !claim) |=> (reg_en == '0 && !rst_out_n));
    assert_no_level_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && !start) |=> (state == ST_OFF));
endmodule

// File: rtl/pb_power_seq.sv
module pb_power_seq
    import pbseq_pkg::*;
#(
    parameter int RST_CYCLES  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pb_in,
    input  logic               wake_in,
    input  logic               pg5,
    input  logic               hold_in,
    input  logic               en_in,
    input  logic               r3_indep,
    output logic [NUM_REG-1:0] reg_en,
    output logic               rst_out_n,
    output logic               pb_stat_n
);
    logic [1:0] trig_s;
    logic       tmr_run, tmr_done;

    pbseq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({wake_in, pb_in}), .q(trig_s)
    );

    pbseq_timer #(.RST_CYCLES(RST_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .pg_ok(pg5), .done(tmr_done)
    );

    pbseq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pb_s(trig_s[0]), .wk_s(trig_s[1]),
        .pg5(pg5), .hold_in(hold_in), .en_in(en_in), .r3_indep(r3_indep),
        .tmr_done(tmr_done), .tmr_run(tmr_run),
        .reg_en(reg_en), .rst_out_n(rst_out_n)
    );

    assign pb_stat_n = ~trig_s[0];

    assert_status_tracks_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pb_stat_n) |-> $past(pb_in, 2));
endmodule

// File: tb/pb_power_seq_tb.sv
module pb_power_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NRST       = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pb_in = 0, wake_in = 0, pg5 = 0, hold_in = 0, en_in = 0, r3_indep = 0;
    logic [6:0] reg_en;
    logic       rst_out_n, pb_stat_n;

    int total = 0, bad = 0;
    string tag = "R1";

    pb_power_seq #(.RST_CYCLES(NRST), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .pb_in(pb_in), .wake_in(wake_in), .pg5(pg5),
        .hold_in(hold_in), .en_in(en_in), .r3_indep(r3_indep),
        .reg_en(reg_en), .rst_out_n(rst_out_n), .pb_stat_n(pb_stat_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference: 0 off, 1 ramp, 2 reset window, 3 boot, 4 on
    int m_st = 0, m_cnt = 0;
    int p1 = 0, p2 = 0, p3 = 0, w1 = 0, w2 = 0, w3 = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; p1 = 0; p2 = 0; p3 = 0; w1 = 0; w2 = 0; w3 = 0;
        end else begin
            int held, claimed, nx;
            held    = (p2 != 0) || (w2 != 0);
            claimed = hold_in || en_in;
            nx      = m_st;
            case (m_st)
                0: if ((p2 && !p3) || (w2 && !w3)) nx = 1;
                1: if (!held) nx = 0; else if (pg5) begin nx = 2; m_cnt = 0; end
                2: if (!held) nx = 0;
                   else if (!pg5) m_cnt = 0;
                   else if (m_cnt == NRST - 1) nx = 3;
                   else m_cnt++;
                3: if (claimed) nx = 4; else if (!held) nx = 0;
                default: if (!claimed) nx = 0;
            endcase
            m_st = nx;
            p3 = p2; p2 = p1; p1 = pb_in;
            w3 = w2; w2 = w1; w1 = wake_in;
        end
    end

    function automatic logic [6:0] exp_en();
        logic [6:0] e = '0;
        case (m_st)
            1: e = 7'b0010100;
            2, 3: e = 7'b0010111;
            4: begin
                e[0] = hold_in; e[1] = hold_in; e[4] = hold_in;
                e[3] = en_in;   e[5] = en_in;   e[6] = en_in;
                e[2] = en_in || (!r3_indep && p2 != 0);
            end
            default: e = '0;
        endcase
        return e;
    endfunction

    task automatic check();
        logic [6:0] ee = exp_en();
        logic er = (m_st >= 3);
        logic es = (p2 == 0);
        total++;
        if (reg_en !== ee || rst_out_n !== er || pb_stat_n !== es) begin
            bad++;
            $display("FAIL %s: en=%b rst_n=%b stat_n=%b expected en=%b rst_n=%b stat_n=%b",
                     tag, reg_en, rst_out_n, pb_stat_n, ee, er, es);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check();
        end
    endtask

    task automatic reach_boot();
        pb_in = 1; step(5);
        pg5 = 1;   step(NRST + 3);
    endtask

    initial begin
        tag = "R1"; step(3);
        rst_n = 1'b1; step(3);

        // R2 R3 R4 R12 R6 R9: push, power-good, claim by hold, release
        tag = "R2"; pb_in = 1; step(4);
        tag = "R3"; pg5 = 1; step(3);
        tag = "R4"; step(NRST);
        tag = "R6"; hold_in = 1; step(3);
        tag = "R9"; pb_in = 0; step(4);
        tag = "R12"; pb_in = 1; step(3); pb_in = 0; step(3);

        // R7 R10: enable takes over, then both drop
        tag = "R7"; en_in = 1; step(2); hold_in = 0; step(3);
        tag = "R10"; en_in = 0; step(3);
        pg5 = 0; step(2);

        // R5: release in ramp, in reset window, and in boot
        tag = "R5"; pb_in = 1; step(4); pb_in = 0; step(4);
        pb_in = 1; step(4); pg5 = 1; step(3); pb_in = 0; step(4);
        pg5 = 0; reach_boot(); pb_in = 0; step(4);

        // R4: power-good dropout restarts the window
        tag = "R4"; pg5 = 0; pb_in = 1; step(5); pg5 = 1; step(NRST - 2);
        pg5 = 0; step(2); pg5 = 1; step(NRST + 2);
        pb_in = 0; step(4);

        // R8 R9: wake start, enable claim, independent reg3 with hold only
        tag = "R8"; pg5 = 0; r3_indep = 1; wake_in = 1; step(5); pg5 = 1; step(NRST + 3);
        en_in = 1; step(2); wake_in = 0; step(3);
        tag = "R9"; pb_in = 1; hold_in = 1; en_in = 0; step(4); pb_in = 0; step(3);

        // R11: button held across shutdown does not restart
        tag = "R11"; pb_in = 1; step(4); hold_in = 0; step(6);
        pb_in = 0; step(3); pb_in = 1; step(5); pb_in = 0; step(4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule